// File: doc/BRIEF.md
# Column-Serial Ones-Count Multiplier

This block multiplies two unsigned P-bit operands and returns the 2P-bit product. It gathers all partial-product bits `a[j] & b[k]` into columns by weight `j+k`. It then reduces the columns one after another with one serial ones counter. The counter starts at the least significant column and works upward. While the counter scans a column it reads one element per clock, and it adds one to the count for each element that is 1.

When a column's scan is complete, bit 0 of the count becomes the product bit for that column. Each higher count bit k is stored as an extra element of the column k places above. No adder tree is used and no shift-and-add is used. The logic per clock is a single small increment plus an element multiplexer.

A pulse on `start_i` captures the operands. The block then runs for a fixed number of cycles that depends only on P, and raises `done_o`. The product stays valid until the next start is accepted.

Top module: `popmul_top`

## Requirements
- R1: After `done_o` rises, `product_o` equals the unsigned product `a_i * b_i` of the operands captured at the accepted start, for every operand pair including 0, 1 and all ones.
- R2: Columns are reduced strictly in order 0, 1, ..., 2P-1. Product bit r is bit 0 of the ones count of column r.
- R3: For each k of 1 or more, count bit k of column r is added as one element of column r+k. A running count never exceeds the number of elements scanned so far in its column.
- R4: Let CW be the smallest w with 2^w > P+w-1. Column r holds `min(r+1, 2P-1-r)` partial-product elements plus `min(CW-1, r)` forwarded slots. Elements are scanned one per clock, and each column spends one extra clock writing its result. `done_o` is first seen high exactly `1 + sum over r of (elements(r)+1)` rising edges after the edge that accepts start. This is 123 edges for P=8 and 38 edges for P=4, independent of the data.
- R5: `done_o` rises one cycle after the last column is written. While `start_i` stays low, `done_o` stays high and `product_o` holds its value, even if the operands change.
- R6: A start pulse while a multiplication is in progress is ignored. The result and the latency are those of the operation already running.
- R7: During and directly after reset, `product_o` is 0 and `done_o` is 0.
- R8: Start is accepted when the block is idle or done. At the next clock `done_o` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Capture operands and begin a multiplication |
| a_i | input | P | Multiplicand, unsigned |
| b_i | input | P | Multiplier, unsigned |
| product_o | output | 2P | Unsigned product |
| done_o | output | 1 | Product valid; held until the next accepted start |

## Verification
Assertions check the following properties on every cycle:
- the column pointer steps by exactly one;
- a running count never overtakes the element index;
- the element index never passes the column's element count;
- captured operands stay unchanged when a start arrives mid-scan;
- the product holds while done is high.

Some properties can only be shown by the bench's scenarios:
- that the forwarded carries land in the right columns, which appears only in the final product against `A*B` over random and extreme operands at two widths;
- the exact, data-independent latency;
- that a start pulse during a scan has no effect on the result.

// File: rtl/popmul_pkg.sv
package popmul_pkg;

  // width of a column count: smallest w with 2^w > p + w - 1
  function automatic int cnt_width(int p);
    int w;
    w = 1;
    while ((1 << w) <= p + w - 1) w++;
    return w;
  endfunction

  function automatic int pp_count(int p, int r);
    return (r < p) ? r + 1 : 2 * p - 1 - r;
  endfunction

  function automatic int pp_low(int p, int r);
    return (r < p) ? 0 : r - p + 1;
  endfunction

  function automatic int slot_count(int cw, int r);
    return (r < cw - 1) ? r : cw - 1;
  endfunction

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_SCAN = 2'd1,
    S_FIN  = 2'd2,
    S_DONE = 2'd3
  } popmul_state_e;

endpackage

// File: rtl/popmul_elem_sel.sv
module popmul_elem_sel
  import popmul_pkg::*;
#(
  parameter int P   = 8,
  parameter int CW  = 4,
  parameter int CLW = 4,
  parameter int IW  = 4
) (
  input  logic [P-1:0]   a_i,
  input  logic [P-1:0]   b_i,
  input  logic [CLW-1:0] col_i,
  input  logic [IW-1:0]  idx_i,
  input  logic [CW-2:0]  carry_i,
  output logic           elem_o,
  output logic [IW-1:0]  nelem_o
);

  int c, ix, n_pp, lo, ns;

  always_comb begin
    c      = int'(col_i);
    ix     = int'(idx_i);
    n_pp   = pp_count(P, c);
    lo     = pp_low(P, c);
    ns     = slot_count(CW, c);
    elem_o = 1'b0;
    if (ix < n_pp) begin
      // partial-product element: j runs upward from the column's low index
      for (int j = 0; j < P; j++) begin
        for (int k = 0; k < P; k++) begin
          if ((j + k == c) && (j == lo + ix)) elem_o = a_i[j] & b_i[k];
        end
      end
    end else begin
      for (int s = 0; s < CW - 1; s++) begin
        if ((s == ix - n_pp) && (s < ns)) elem_o = carry_i[s];
      end
    end
    nelem_o = IW'(n_pp + ns);
  end

endmodule

// File: rtl/popmul_counter.sv
module popmul_counter #(
  parameter int CW = 4,
  parameter int IW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          en_i,
  input  logic          elem_i,
  input  logic [IW-1:0] nelem_i,
  output logic [CW-1:0] cnt_o,
  output logic          scan_end_o
);

  logic [CW-1:0] cnt_q;
  logic [IW-1:0] idx_q;

  assign scan_end_o = (idx_q == nelem_i);
  assign cnt_o      = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      idx_q <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
      idx_q <= '0;
    end else if (en_i && !scan_end_o) begin
      cnt_q <= cnt_q + CW'(elem_i);
      idx_q <= idx_q + 1'b1;
    end
  end

  logic [IW-1:0] idx_of_out;
  assign idx_of_out = idx_q;

  assert_cnt_le_idx_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(cnt_q) <= 32'(idx_q));

  assert_idx_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (idx_of_out <= nelem_i));

endmodule

// File: rtl/popmul_carry_bank.sv
module popmul_carry_bank #(
  parameter int NCOL = 16,
  parameter int CW   = 4,
  parameter int CLW  = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clear_i,
  input  logic           wr_en_i,
  input  logic [CLW-1:0] col_i,
  input  logic [CW-1:0]  cnt_i,
  output logic [CW-2:0]  carry_o
);

  // slot s of column c holds count bit s+1 of column c-s-1
  logic [CW-2:0] slot_q [NCOL];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < NCOL; c++) slot_q[c] <= '0;
    end else if (clear_i) begin
      for (int c = 0; c < NCOL; c++) slot_q[c] <= '0;
    end else if (wr_en_i) begin
      for (int c = 0; c < NCOL; c++) begin
        for (int s = 0; s < CW - 1; s++) begin
          if ((c >= s + 1) && (int'(col_i) == c - s - 1)) slot_q[c][s] <= cnt_i[s+1];
        end
      end
    end
  end

  assign carry_o = slot_q[col_i];

endmodule

// File: rtl/popmul_top.sv
module popmul_top
  import popmul_pkg::*;
#(
  parameter int P = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [P-1:0]   a_i,
  input  logic [P-1:0]   b_i,
  output logic [2*P-1:0] product_o,
  output logic           done_o
);

  localparam int NCOL = 2 * P;
  localparam int CW   = cnt_width(P);
  localparam int CLW  = $clog2(NCOL);
  localparam int IW   = $clog2(P + CW);
  localparam logic [CLW-1:0] LAST_COL = CLW'(NCOL - 1);

  popmul_state_e  state_q;
  logic [P-1:0]   a_q, b_q;
  logic [CLW-1:0] col_q;
  logic [2*P-1:0] prod_q;
  logic           accept, scan, col_wr, elem;
  logic [IW-1:0]  nelem;
  logic [CW-1:0]  cnt;
  logic [CW-2:0]  carry;
  logic           scan_end;

  assign accept = start_i && ((state_q == S_IDLE) || (state_q == S_DONE));
  assign scan   = (state_q == S_SCAN);
  assign col_wr = scan && scan_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      a_q     <= '0;
      b_q     <= '0;
      col_q   <= '0;
      prod_q  <= '0;
    end else begin
      unique case (state_q)
        S_IDLE, S_DONE: if (accept) begin
          state_q <= S_SCAN;
          a_q     <= a_i;
          b_q     <= b_i;
          col_q   <= '0;
          prod_q  <= '0;
        end
        S_SCAN: if (col_wr) begin
          prod_q[col_q] <= cnt[0];
          if (col_q == LAST_COL) state_q <= S_FIN;
          else                   col_q   <= col_q + 1'b1;
        end
        S_FIN: state_q <= S_DONE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  popmul_elem_sel #(.P(P), .CW(CW), .CLW(CLW), .IW(IW)) u_sel (
    .a_i(a_q), .b_i(b_q), .col_i(col_q), .idx_i(u_cnt.idx_of_out),
    .carry_i(carry), .elem_o(elem), .nelem_o(nelem)
  );

  popmul_counter #(.CW(CW), .IW(IW)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(accept || col_wr), .en_i(scan),
    .elem_i(elem), .nelem_i(nelem), .cnt_o(cnt), .scan_end_o(scan_end)
  );

  popmul_carry_bank #(.NCOL(NCOL), .CW(CW), .CLW(CLW)) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(accept), .wr_en_i(col_wr),
    .col_i(col_q), .cnt_i(cnt), .carry_o(carry)
  );

  assign product_o = prod_q;
  assign done_o    = (state_q == S_DONE);

  assert_col_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_wr && col_q != LAST_COL) |=> (col_q == $past(col_q) + 1'b1));

  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (done_o && $stable(product_o)));

  assert_busy_start_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scan && start_i) |=> ($stable(a_q) && $stable(b_q) && !done_o));

  assert_start_clears_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && start_i) |=> !done_o);

endmodule

// File: tb/popmul_top_tb.sv
`timescale 1ns/1ps
module popmul_top_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] a8 = '0, b8 = '0;
  logic [3:0] a4 = '0, b4 = '0;
  logic [15:0] p8;
  logic [7:0]  p4;
  logic d8, d4;
  int n_tests = 0, n_fail = 0;

  always #2 clk = ~clk;

  popmul_top #(.P(8)) u_dut (.clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .a_i(a8), .b_i(b8), .product_o(p8), .done_o(d8));
  popmul_top #(.P(4)) u_dut4 (.clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .a_i(a4), .b_i(b4), .product_o(p4), .done_o(d4));

  function automatic int exp_cw(int p);
    int w = 1;
    while ((1 << w) <= p + w - 1) w++;
    return w;
  endfunction

  function automatic int exp_latency(int p);
    int cw = exp_cw(p), tot = 1;
    for (int r = 0; r < 2 * p; r++) begin
      int npp = (r < p) ? r + 1 : 2 * p - 1 - r;
      int ns  = (r < cw - 1) ? r : cw - 1;
      tot += npp + ns + 1;
    end
    return tot;
  endfunction

  task automatic check(bit ok, string req, longint act, longint expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // one multiplication on both widths; inject>0 pulses start mid-scan
  task automatic run(logic [7:0] x8, logic [7:0] y8, logic [3:0] x4, logic [3:0] y4, int inject);
    int n = 0, l8 = -1, l4 = -1;
    @(negedge clk);
    a8 = x8; b8 = y8; a4 = x4; b4 = y4; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    n = 1;
    check(!d8 && !d4, "R8 done low after accept", longint'(d8), 0);
    while ((l8 < 0 || l4 < 0) && n < 1000) begin
      if (inject > 0 && n == inject) begin
        a8 = ~x8; b8 = 8'h5a; a4 = ~x4; b4 = 4'h3; start = 1'b1;
      end else start = 1'b0;
      @(posedge clk);
      @(negedge clk);
      if (d4 && l4 < 0) l4 = n;
      if (d8 && l8 < 0) l8 = n;
      n++;
    end
    start = 1'b0;
    check(l8 == exp_latency(8), "R4 latency P8", l8, exp_latency(8));
    check(l4 == exp_latency(4), "R4 latency P4", l4, exp_latency(4));
    check(p8 == 16'(x8) * 16'(y8), "R1 R2 R3 product P8", p8, 16'(x8) * 16'(y8));
    check(p4 == 8'(x4) * 8'(y4), "R1 R2 R3 product P4", p4, 8'(x4) * 8'(y4));
  endtask

  initial begin
    #300000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] held;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(p8 == 0 && !d8, "R7 reset P8", p8, 0);
    check(p4 == 0 && !d4, "R7 reset P4", p4, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(p8 == 0 && !d8 && !d4, "R7 after reset", p8, 0);

    run(8'h00, 8'h00, 4'h0, 4'h0, 0);
    run(8'h01, 8'h01, 4'h1, 4'h1, 0);
    run(8'hff, 8'hff, 4'hf, 4'hf, 0);   // R3 tallest columns
    run(8'hff, 8'h01, 4'hf, 4'h1, 0);
    run(8'h00, 8'hff, 4'h0, 4'hf, 0);
    run(8'h80, 8'h80, 4'h8, 4'h8, 0);   // R2 top column only carries

    // R5 hold while operands change
    held = p8;
    @(negedge clk);
    a8 = 8'h12; b8 = 8'h34;
    repeat (5) @(negedge clk);
    check(d8 && p8 == held, "R5 hold product", p8, held);

    // R6 start mid-scan ignored
    run(8'hc3, 8'h7e, 4'hb, 4'h6, 10);

    for (int i = 0; i < 40; i++) begin
      logic [31:0] r = $urandom;
      run(r[7:0], r[15:8], r[19:16], r[23:20], 0);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule